// File: doc/BRIEF.md
# 10 Mbps Receive Polarity Corrector

This block watches the 10 Mbps twisted-pair receive path for a swapped wire pair and undoes the swap. Upstream logic has already qualified the analog pulses, so the block sees single-cycle events: a link pulse with a sign flag, a start-of-idle pulse with a sign flag, and frame start and frame end strobes. It keeps a belief about the line polarity, reports it as a status bit, inverts the received data bus while the line is judged reversed, and flags the frames that follow a correction so that later logic can drop them.

The belief changes on disagreeing evidence. Three link pulses in a row whose sign disagrees with the current belief flip it. A single disagreeing start-of-idle pulse also flips it. An agreeing link pulse clears the run. At 100 Mbps the whole function is idle: the status is held clear, data passes through and no frame is flagged. A disable input stops the data inversion and the frame flagging while the status bit keeps reporting.

Top module: `rx_polarity_corrector`

## Requirements
- R1: While `speed100` is 1, pulse inputs are ignored, `revPolarity` reads 0 from the cycle after `speed100` is sampled high, `rxDataOut` equals `rxDataIn`, and no pending frame discards remain, so frames started after returning to 10 Mbps are not flagged.
- R2: With `revPolarity` at 0, three consecutive link pulses with `linkPulseNeg` = 1 (negative sign = wrong) set `revPolarity` on the clock edge that samples the third pulse.
- R3: A link pulse whose sign agrees with the current belief (`linkPulseNeg` equal to `revPolarity`) clears the run of disagreeing pulses, so neg, neg, pos, neg, neg leaves `revPolarity` at 0.
- R4: One start-of-idle pulse whose sign disagrees with `revPolarity` flips `revPolarity` on the edge that samples it. If a start-of-idle pulse and a link pulse arrive in the same cycle, only the start-of-idle pulse is used.
- R5: At 10 Mbps with `autoPolDis` = 0, `rxDataOut` is the bitwise inverse of `rxDataIn` in every cycle where `revPolarity` is 1, and equal to `rxDataIn` otherwise. The path is combinational.
- R6: With `autoPolDis` = 1, `revPolarity` still follows R2, R4 and R7. `rxDataOut` equals `rxDataIn`, and a flip arms no frame discards.
- R7: While `revPolarity` is 1, three consecutive link pulses with `linkPulseNeg` = 0, or one start-of-idle pulse with `idlePulseNeg` = 0, clear `revPolarity`.
- R8: Each flip of `revPolarity` made at 10 Mbps with `autoPolDis` = 0 arms discard of the next 3 frames. A frame start in the same cycle as the flip is not counted. For each armed frame, `frameDiscard` is 1 from the cycle after its `frameStart` through the cycle of its `frameEnd`, and it drops after the `frameEnd` edge. The fourth frame is not flagged.
- R9: After reset, `revPolarity` and `frameDiscard` are 0, no discards are pending, and `rxDataOut` equals `rxDataIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| speed100 | input | 1 | 1 = 100 Mbps (function idle), 0 = 10 Mbps |
| autoPolDis | input | 1 | 1 = report polarity only, do not correct |
| linkPulse | input | 1 | Qualified link pulse strobe |
| linkPulseNeg | input | 1 | Sign of the link pulse, 1 = negative (wrong) |
| idlePulse | input | 1 | Qualified start-of-idle pulse strobe |
| idlePulseNeg | input | 1 | Sign of the start-of-idle pulse, 1 = negative (wrong) |
| frameStart | input | 1 | First cycle of a received frame |
| frameEnd | input | 1 | Last cycle of a received frame |
| rxDataIn | input | DATA_W | Receive data before correction |
| rxDataOut | output | DATA_W | Receive data after correction |
| revPolarity | output | 1 | Reverse-polarity status |
| frameDiscard | output | 1 | Current frame follows a correction and must be dropped |

## Verification
The assertions check, on every cycle, properties that hold in any state. A disagreeing start-of-idle pulse always flips the belief on the next edge. The disagreement run never reaches its threshold. Running at 100 Mbps always leaves the status, pending discards and the frame flag clear. A frame end without a new mark always drops the flag. A correction always loads the full discard count. Some behaviour depends on event order, and only the directed scenarios show it: the run reset by an agreeing link pulse in the middle, reversal back to normal polarity, the exact frame count after a correction with the fourth frame passing, the data inversion pattern, and the split made by the disable input between reporting and correcting.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;
  // Strobes from the polarity control to the datapath
  typedef struct packed {
    logic invert;     // apply inversion to the data bus this cycle
    logic markFrame;  // frame starting now must be flagged for discard
    logic clearAll;   // 100 Mbps: drop any frame flag
  } polStrobes_t;
endpackage

// File: rtl/rxpol_ctrl.sv
module rxpol_ctrl
  import rxpol_pkg::*;
#(
  parameter int LINK_THRESH    = 3,
  parameter int DISCARD_FRAMES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        speed100,
  input  logic        autoPolDis,
  input  logic        linkPulse,
  input  logic        linkPulseNeg,
  input  logic        idlePulse,
  input  logic        idlePulseNeg,
  input  logic        frameStart,
  output logic        revPol,
  output polStrobes_t strobes
);
  localparam int CNT_W  = $clog2(LINK_THRESH + 1);
  localparam int DISC_W = $clog2(DISCARD_FRAMES + 1);
  localparam logic [CNT_W-1:0]  RUN_LAST  = CNT_W'(LINK_THRESH - 1);
  localparam logic [DISC_W-1:0] DISC_LOAD = DISC_W'(DISCARD_FRAMES);

  logic [CNT_W-1:0]  runCnt, runCntNext;
  logic [DISC_W-1:0] discLeft, discLeftNext;
  logic              flipNow;
  logic              armDiscard;

  // Evidence evaluation: the start-of-idle pulse wins over a link pulse
  always_comb begin
    flipNow    = 1'b0;
    runCntNext = runCnt;
    if (idlePulse) begin
      runCntNext = '0;
      if (idlePulseNeg != revPol) flipNow = 1'b1;
    end else if (linkPulse) begin
      if (linkPulseNeg != revPol) begin
        if (runCnt == RUN_LAST) begin
          flipNow    = 1'b1;
          runCntNext = '0;
        end else begin
          runCntNext = runCnt + 1'b1;
        end
      end else begin
        runCntNext = '0;
      end
    end
  end

  assign armDiscard = flipNow && !autoPolDis;

  always_comb begin
    discLeftNext = discLeft;
    if (armDiscard)
      discLeftNext = DISC_LOAD;
    else if (frameStart && discLeft != '0)
      discLeftNext = discLeft - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || speed100) begin
      runCnt   <= '0;
      revPol   <= 1'b0;
      discLeft <= '0;
    end else begin
      runCnt   <= runCntNext;
      discLeft <= discLeftNext;
      if (flipNow) revPol <= !revPol;
    end
  end

  always_comb begin
    strobes.invert    = revPol && !autoPolDis && !speed100;
    strobes.markFrame = frameStart && (discLeft != '0) && !armDiscard && !speed100;
    strobes.clearAll  = speed100;
  end

  // R4
  idle_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!speed100 && idlePulse && (idlePulseNeg != revPol)) |=> (revPol != $past(revPol)));

  // R2
  run_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    runCnt < CNT_W'(LINK_THRESH));

  // R1
  slow_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    speed100 |=> (!revPol && discLeft == '0 && runCnt == '0));

  // R8
  disc_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!speed100 && !autoPolDis && $changed(revPol) && $past(!speed100)) |-> (discLeft == DISC_LOAD));

  // R8
  disc_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    discLeft <= DISC_LOAD);
endmodule

// File: rtl/rxpol_dpath.sv
module rxpol_dpath
  import rxpol_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  polStrobes_t       strobes,
  input  logic              frameEnd,
  input  logic [DATA_W-1:0] rxDataIn,
  output logic [DATA_W-1:0] rxDataOut,
  output logic              frameDiscard
);
  logic discardQ;

  assign rxDataOut    = rxDataIn ^ {DATA_W{strobes.invert}};
  assign frameDiscard = discardQ;

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearAll)
      discardQ <= 1'b0;
    else if (strobes.markFrame)
      discardQ <= 1'b1;
    else if (frameEnd)
      discardQ <= 1'b0;
  end

  // R8
  end_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && !strobes.markFrame) |=> !frameDiscard);

  // R1
  slow_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> !frameDiscard);

  // R8
  mark_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.markFrame && !strobes.clearAll) |=> frameDiscard);
endmodule

// File: rtl/rx_polarity_corrector.sv
module rx_polarity_corrector
  import rxpol_pkg::*;
#(
  parameter int DATA_W         = 4,
  parameter int LINK_THRESH    = 3,
  parameter int DISCARD_FRAMES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              speed100,
  input  logic              autoPolDis,
  input  logic              linkPulse,
  input  logic              linkPulseNeg,
  input  logic              idlePulse,
  input  logic              idlePulseNeg,
  input  logic              frameStart,
  input  logic              frameEnd,
  input  logic [DATA_W-1:0] rxDataIn,
  output logic [DATA_W-1:0] rxDataOut,
  output logic              revPolarity,
  output logic              frameDiscard
);
  polStrobes_t strobes;

  rxpol_ctrl #(
    .LINK_THRESH   (LINK_THRESH),
    .DISCARD_FRAMES(DISCARD_FRAMES)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .speed100    (speed100),
    .autoPolDis  (autoPolDis),
    .linkPulse   (linkPulse),
    .linkPulseNeg(linkPulseNeg),
    .idlePulse   (idlePulse),
    .idlePulseNeg(idlePulseNeg),
    .frameStart  (frameStart),
    .revPol      (revPolarity),
    .strobes     (strobes)
  );

  rxpol_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .frameEnd    (frameEnd),
    .rxDataIn    (rxDataIn),
    .rxDataOut   (rxDataOut),
    .frameDiscard(frameDiscard)
  );

  // R5
  data_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    (speed100 || autoPolDis || !revPolarity) |-> (rxDataOut == rxDataIn));
endmodule

// File: tb/sim_rx_polarity_corrector.sv
`timescale 1ns/1ps
module sim_rx_polarity_corrector;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rstN, speed100, autoPolDis;
  logic linkPulse, linkPulseNeg, idlePulse, idlePulseNeg;
  logic frameStart, frameEnd;
  logic [DW-1:0] rxDataIn, rxDataOut;
  logic revPolarity, frameDiscard;

  int vecCnt = 0;
  int badCnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_polarity_corrector #(.DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .speed100(speed100), .autoPolDis(autoPolDis),
    .linkPulse(linkPulse), .linkPulseNeg(linkPulseNeg),
    .idlePulse(idlePulse), .idlePulseNeg(idlePulseNeg),
    .frameStart(frameStart), .frameEnd(frameEnd),
    .rxDataIn(rxDataIn), .rxDataOut(rxDataOut),
    .revPolarity(revPolarity), .frameDiscard(frameDiscard)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vecCnt++;
    if (act !== exp) begin
      badCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; speed100 = 1'b0; autoPolDis = 1'b0;
    linkPulse = 1'b0; linkPulseNeg = 1'b0; idlePulse = 1'b0; idlePulseNeg = 1'b0;
    frameStart = 1'b0; frameEnd = 1'b0; rxDataIn = 4'hA;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic link(input logic neg);
    linkPulse = 1'b1; linkPulseNeg = neg;
    @(negedge clk);
    linkPulse = 1'b0;
  endtask

  task automatic idle(input logic neg);
    idlePulse = 1'b1; idlePulseNeg = neg;
    @(negedge clk);
    idlePulse = 1'b0;
  endtask

  // One frame; checks the flag during and after it
  task automatic frame(input string tag, input logic expDisc);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    check(tag, {3'b0, frameDiscard}, {3'b0, expDisc});
    @(negedge clk);
    frameEnd = 1'b1;
    #1 check(tag, {3'b0, frameDiscard}, {3'b0, expDisc});
    @(negedge clk);
    frameEnd = 1'b0;
    check(tag, {3'b0, frameDiscard}, 4'h0);
  endtask

  task automatic tResetState();
    doReset();
    check("R9 status", {3'b0, revPolarity}, 4'h0);
    check("R9 discard", {3'b0, frameDiscard}, 4'h0);
    check("R9 data", rxDataOut, rxDataIn);
    frame("R9 no pending", 1'b0);
  endtask

  task automatic tLinkTrip();
    doReset();
    link(1'b1); link(1'b1);
    check("R2 two pulses", {3'b0, revPolarity}, 4'h0);
    link(1'b1);
    check("R2 third pulse", {3'b0, revPolarity}, 4'h1);
    rxDataIn = 4'h3;
    #1 check("R5 inverted", rxDataOut, 4'hC);
    rxDataIn = 4'hA;
  endtask

  task automatic tLinkRunReset();
    doReset();
    link(1'b1); link(1'b1); link(1'b0); link(1'b1); link(1'b1);
    check("R3 run cleared", {3'b0, revPolarity}, 4'h0);
    #1 check("R5 passthrough", rxDataOut, 4'hA);
    link(1'b1);
    check("R3 new run of three", {3'b0, revPolarity}, 4'h1);
  endtask

  task automatic tIdle();
    doReset();
    idle(1'b1);
    check("R4 single idle", {3'b0, revPolarity}, 4'h1);
    doReset();
    link(1'b1); link(1'b1);
    linkPulse = 1'b1; linkPulseNeg = 1'b1; idlePulse = 1'b1; idlePulseNeg = 1'b0;
    @(negedge clk);
    linkPulse = 1'b0; idlePulse = 1'b0;
    check("R4 idle has priority", {3'b0, revPolarity}, 4'h0);
  endtask

  task automatic tRevert();
    doReset();
    idle(1'b1);
    link(1'b0); link(1'b0);
    check("R7 two good pulses", {3'b0, revPolarity}, 4'h1);
    link(1'b0);
    check("R7 link revert", {3'b0, revPolarity}, 4'h0);
    idle(1'b1);
    idle(1'b0);
    check("R7 idle revert", {3'b0, revPolarity}, 4'h0);
  endtask

  task automatic tDiscard();
    doReset();
    idle(1'b1);
    frame("R8 frame 1", 1'b1);
    frame("R8 frame 2", 1'b1);
    frame("R8 frame 3", 1'b1);
    frame("R8 frame 4", 1'b0);
    // flip back also arms
    idle(1'b0);
    frame("R8 after revert", 1'b1);
    // frame start in the flip cycle is not counted
    doReset();
    idlePulse = 1'b1; idlePulseNeg = 1'b1; frameStart = 1'b1;
    @(negedge clk);
    idlePulse = 1'b0; frameStart = 1'b0;
    check("R8 same-cycle start", {3'b0, frameDiscard}, 4'h0);
    frameEnd = 1'b1;
    @(negedge clk);
    frameEnd = 1'b0;
    frame("R8 first counted", 1'b1);
  endtask

  task automatic tAutoDis();
    doReset();
    autoPolDis = 1'b1;
    idle(1'b1);
    check("R6 status reported", {3'b0, revPolarity}, 4'h1);
    #1 check("R6 no inversion", rxDataOut, 4'hA);
    frame("R6 no discard", 1'b0);
    autoPolDis = 1'b0;
    #1 check("R5 inversion on enable", rxDataOut, 4'h5);
  endtask

  task automatic tSpeed100();
    doReset();
    speed100 = 1'b1;
    @(negedge clk);
    idle(1'b1);
    link(1'b1); link(1'b1); link(1'b1);
    check("R1 pulses ignored", {3'b0, revPolarity}, 4'h0);
    check("R1 data passthrough", rxDataOut, 4'hA);
    speed100 = 1'b0;
    idle(1'b1);
    check("R1 10M trip", {3'b0, revPolarity}, 4'h1);
    speed100 = 1'b1;
    #1 check("R1 data at 100M", rxDataOut, 4'hA);
    @(negedge clk);
    check("R1 status cleared", {3'b0, revPolarity}, 4'h0);
    speed100 = 1'b0;
    frame("R1 pending cleared", 1'b0);
  endtask

  initial begin
    rstN = 1'b0;
    tResetState();
    tLinkTrip();
    tLinkRunReset();
    tIdle();
    tRevert();
    tDiscard();
    tAutoDis();
    tSpeed100();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, badCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vecCnt++;
      badCnt++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, badCnt);
      $finish;
    end
  end
endmodule